// File: doc/BRIEF.md
# Glitch-Free Three-State Clock Gate

This block derives a downstream clock from a fast free-running reference clock. A slow controller chooses the output state with a two-bit code: drive the derived clock steadily low, drive it steadily high, or let it toggle freely. The controller uses the steady states to step a downstream serial register one edge at a time, so it can shift in control words. It can also turn the free-running state on and off to thin out sampling and obtain slower effective timebases.

The mode code comes from another clock domain. It passes through a chain of synchronizer flops before use. The derived clock is the output of a single flop clocked by the reference. Every change of mode therefore lands on a clean reference edge, and the output cannot show a runt pulse or a shortened phase.

Top module: `gclk_gate`

## Requirements
- R1: While `rst_n` is low, `gclk` is 0 and the synchronizer holds the hold-low code 2'b00.
- R2: Code 2'b00 (hold low) drives `gclk` to 0 and keeps it there.
- R3: Code 2'b01 (hold high) drives `gclk` to 1 and keeps it there.
- R4: Code 2'b10 (run) inverts `gclk` at every rising reference edge, so each phase lasts exactly one reference period.
- R5: Code 2'b11 (freeze) keeps `gclk` at whatever level it has, including a level reached in the middle of a run.
- R6: A code that is first captured at rising edge k decides the value `gclk` takes at rising edge k+SYNC_STAGES. This is SYNC_STAGES+1 rising edges after the code is applied.
- R7: `gclk` changes only on a rising reference edge, and at most once per edge. No high or low phase is shorter than one reference period.
- R8: When run follows hold high, the first change of `gclk` is to low, and that low phase lasts a full reference period.
- R9: Alternating hold-low and hold-high codes gives exactly one output edge per code change. A code held for a single controller cycle still produces a full-width phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Mode code from the controller, asynchronous to `clk` |
| gclk | output | 1 | Derived clock, driven straight from a flop |

## Verification
Each code takes effect on `gclk` SYNC_STAGES+1 rising edges after the bench drives it, which is three edges with the default setting. The driver applies one code per cycle at the falling edge and pushes it into a queue. The queue is pre-loaded with the codes already held in the synchronizer at reset release. The monitor samples just after each falling edge and pops one code per cycle, but only once the queue is deeper than the pipeline. Each popped code is applied to a model of the output level, which is compared with `gclk` exactly in the cycle that code governs. A separate watcher timestamps every `gclk` transition and checks the minimum phase width against the reference period.

// File: rtl/gclk_gate.sv
module gclk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  output logic       gclk
);
  localparam logic [1:0] M_LOW  = 2'b00;
  localparam logic [1:0] M_HIGH = 2'b01;
  localparam logic [1:0] M_RUN  = 2'b10;

  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] mode_s;
  logic       gclk_q;
  logic       gclk_d;

  // R1, R6: synchronizer chain, cleared to hold-low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= M_LOW;
    end else begin
      sync_q[0] <= mode_req;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign mode_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    case (mode_s)
      M_LOW:   gclk_d = 1'b0;
      M_HIGH:  gclk_d = 1'b1;
      M_RUN:   gclk_d = ~gclk_q;
      default: gclk_d = gclk_q;
    endcase
  end

  // R7: output taken straight from one flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gclk_q <= 1'b0;
    else        gclk_q <= gclk_d;
  end

  assign gclk = gclk_q;
endmodule

// File: rtl/gclk_gate_chk.sv
module gclk_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_s,
  input logic       gclk
);
  // R2
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == 2'b00) |=> !gclk);

  // R3
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == 2'b01) |=> gclk);

  // R4
  run_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == 2'b10) |=> (gclk != $past(gclk)));

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s == 2'b11) |=> $stable(gclk));
endmodule

bind gclk_gate gclk_gate_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_s (mode_s),
  .gclk   (gclk)
);

// File: tb/gclk_gate_tb.sv
`timescale 1ns/1ps
module gclk_gate_tb;
  localparam int  STAGES = 2;
  localparam real TCLK   = 5.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic       gclk;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  mon_en = 1'b0;
  bit  done = 1'b0;
  logic [1:0] q [$];
  logic exp_g = 1'b0;
  real t_last = 0.0;
  bit  seen_edge = 1'b0;

  always #2.5 clk = ~clk;

  gclk_gate #(.SYNC_STAGES(STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .gclk(gclk)
  );

  task automatic drive(input logic [1:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mode_req = m;
      q.push_back(m);
    end
  endtask

  // Scoreboard monitor: R2..R6 through the pipeline-delayed model
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      while (q.size() > STAGES + 1) begin
        logic [1:0] m;
        string rq;
        m = q.pop_front();
        case (m)
          2'b00: begin exp_g = 1'b0;   rq = "R2/R6"; end
          2'b01: begin exp_g = 1'b1;   rq = "R3/R6"; end
          2'b10: begin exp_g = ~exp_g; rq = "R4/R6"; end
          default: rq = "R5/R6";
        endcase
        n_cmp++;
        if (gclk !== exp_g) begin
          n_bad++;
          $display("FAIL %s: gclk=%0b expected %0b at %0t", rq, gclk, exp_g, $time);
        end
      end
    end
  end

  // R7, R8: phase width watcher
  always @(gclk) begin
    if (mon_en) begin
      if (seen_edge) begin
        n_cmp++;
        if ($realtime - t_last < TCLK - 0.01) begin
          n_bad++;
          $display("FAIL R7: phase %0.3f ns expected >= %0.3f ns", $realtime - t_last, TCLK);
        end
      end
      seen_edge = 1'b1;
      t_last = $realtime;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < STAGES + 1; i++) q.push_back(2'b00);
    // R1: reset holds gclk low even with a run code applied
    mode_req = 2'b10;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (gclk !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: gclk=%0b expected 0 in reset", gclk);
    end
    mode_req = 2'b00;
    rst_n = 1'b1;
    @(posedge clk);
    mon_en = 1'b1;

    drive(2'b00, 6);                 // R2
    drive(2'b01, 6);                 // R3
    drive(2'b10, 9);                 // R4
    drive(2'b11, 5);                 // R5 freeze mid-run
    drive(2'b10, 3);
    drive(2'b11, 4);
    drive(2'b01, 5);
    drive(2'b10, 8);                 // R8 run entered from hold high
    for (int k = 0; k < 8; k++) begin // R9 stepping
      drive(2'b00, 3);
      drive(2'b01, 3);
    end
    drive(2'b00, 4);                 // R9 one-cycle request
    drive(2'b01, 1);
    drive(2'b00, 4);
    for (int k = 0; k < 6; k++) begin // thinned run, R4/R5
      drive(2'b10, 4);
      drive(2'b11, 3);
    end
    for (int k = 0; k < 400; k++)    // random mix, R6/R7
      drive(2'($urandom_range(0, 3)), int'($urandom_range(1, 8)));
    drive(2'b00, STAGES + 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule